// File: doc/BRIEF.md
# SD Host Interrupt Status Register

This block holds the event flags of an SD host controller. The command path and the data path each raise single-cycle event pulses. Examples are a command finishing, a transfer finishing, the buffer being ready for a write or a read, and a set of error conditions. A pulse is captured into a sticky flag only if the matching enable bit is set in a companion enable register.

Software clears flags by writing ones. Each 1 in the written word clears the flag at that position, and each 0 leaves its flag alone. One read-only summary bit reports whether any error flag is set. A single interrupt line is raised while any flag is held.

Event sources are external. In this project the testbench drives them.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset, `stat_o`, `ie_o` and `irq_o` are all zero.
- R2: An event pulse on `evt_i[n]` whose enable bit `ie_o[n]` is 1 sets `stat_o[n]` one clock edge later. The capturable positions are:
  - 0: command done
  - 1: transfer done
  - 4: write buffer ready
  - 5: read buffer ready
  - 16: command timeout
  - 17: command CRC
  - 18: command end bit
  - 19: command index
  - 20: data timeout
  - 21: data CRC
  - 22: data end bit
  - 28: card error
  - 29: bad access
- R3: An event pulse whose enable bit is 0 leaves `stat_o` unchanged.
- R4: A status write (`stat_we_i`=1) clears exactly the held flags where `wdata_i` is 1. All other flags keep their value.
- R5: A status write of 32'hFFFF_FFFF with no simultaneous events makes `stat_o` read 0 and drops `irq_o` on the next cycle.
- R6: If an enabled event arrives in the same cycle as a write that clears its flag, the flag stays set.
- R7: `stat_o[15]` reads 1 exactly when any of `stat_o[31:16]` is 1. Neither a write nor an event on bit 15 can set it.
- R8: `irq_o` is 1 exactly when any bit of `stat_o` is 1.
- R9: Positions outside the R2 list read 0 in both `stat_o` and `ie_o`.
- R10: An enable write (`ie_we_i`=1) loads `ie_o` with `wdata_i` masked to the R2 positions. The value holds until the next enable write.
- R11: With no status write, a held flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Event pulses, one per bit position |
| stat_we_i | input | 1 | Write-one-to-clear strobe for the status register |
| ie_we_i | input | 1 | Write strobe for the enable register |
| wdata_i | input | 32 | Write data for either register |
| stat_o | output | 32 | Status read value including the summary bit |
| ie_o | output | 32 | Enable register read value |
| irq_o | output | 1 | Interrupt, high while any flag is held |

## Verification
Every result in this block is due exactly one clock edge after the stimulus that causes it:
- Event captures, clears, enable loads and the interrupt all appear after that one edge.
- The summary bit and `irq_o` follow the held flags combinationally, with no extra delay.

The bench drives inputs on the falling edge and advances its reference model on the rising edge. It compares all outputs a short delay after that rising edge, so each comparison sees the state produced by the stimulus of the preceding half cycle.

// File: rtl/sdh_irq_status.sv
module sdh_irq_status #(
  parameter int          DW         = 32,
  parameter logic [31:0] EVENT_MASK = 32'h307F_0033,
  parameter int          SUM_BIT    = 15,
  parameter int          ERR_LO     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_i,
  input  logic          stat_we_i,
  input  logic          ie_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] ie_o,
  output logic          irq_o
);

  localparam logic [DW-1:0] SUM_ONE  = {{(DW-1){1'b0}}, 1'b1} << SUM_BIT;
  localparam logic [DW-1:0] CAP_MASK = EVENT_MASK[DW-1:0] & ~SUM_ONE;

  logic [DW-1:0] held, ena;
  logic [DW-1:0] clr, set;
  logic          err_any;

  assign clr = stat_we_i ? wdata_i : '0;
  assign set = evt_i & ena & CAP_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= '0;
      ena  <= '0;
    end else begin
      held <= ((held & ~clr) | set) & CAP_MASK;
      if (ie_we_i) ena <= wdata_i & CAP_MASK;
    end
  end

  assign err_any = |held[DW-1:ERR_LO];
  assign stat_o  = held | (err_any ? SUM_ONE : '0);
  assign ie_o    = ena;
  assign irq_o   = |held;

endmodule

// File: rtl/sdh_irq_status_chk.sv
module sdh_irq_status_chk #(
  parameter logic [31:0] EVENT_MASK = 32'h307F_0033
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] evt_i,
  input logic        stat_we_i,
  input logic [31:0] wdata_i,
  input logic [31:0] stat_o,
  input logic [31:0] ie_o,
  input logic        irq_o
);
  localparam logic [31:0] CAP = EVENT_MASK & ~32'h0000_8000;

  logic [31:0] enabled_evt;
  assign enabled_evt = evt_i & ie_o & CAP;

  p_event_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled_evt != 0) |=> ((stat_o & $past(enabled_evt)) == $past(enabled_evt)));

  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((stat_o & ~$past(stat_o)) & ~32'h0000_8000 & ~$past(enabled_evt)) == 0));

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we_i |=> ((stat_o & $past(stat_o & CAP)) == $past(stat_o & CAP)));

  p_summary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[15] == (|stat_o[31:16]));

  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|stat_o));

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_o & ~(CAP | 32'h0000_8000)) == 0) && ((ie_o & ~CAP) == 0));
endmodule

bind sdh_irq_status sdh_irq_status_chk #(.EVENT_MASK(EVENT_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .stat_we_i(stat_we_i),
  .wdata_i(wdata_i), .stat_o(stat_o), .ie_o(ie_o), .irq_o(irq_o)
);

// File: tb/sdh_irq_status_bench.sv
module sdh_irq_status_bench;
  localparam logic [31:0] CAPM = 32'h307F_0033;

  logic clk = 0, rst_n = 0;
  logic [31:0] evt_i = 0, wdata_i = 0;
  logic stat_we_i = 0, ie_we_i = 0;
  logic [31:0] stat_o, ie_o;
  logic irq_o;
  int checks = 0, fails = 0;
  logic [31:0] m_stat = 0, m_ie = 0;

  always #5 clk = ~clk;

  sdh_irq_status u_sdh_irq_status (.*);

  function automatic logic [31:0] view(input logic [31:0] s);
    return s | ((|s[31:16]) ? 32'h0000_8000 : 32'h0);
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s, e, ie, input logic we, input logic [31:0] wd);
    return ((s & ~(we ? wd : 32'h0)) | (e & ie)) & CAPM;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [31:0] e, input logic swe, iwe, input logic [31:0] wd);
    @(negedge clk);
    evt_i = e; stat_we_i = swe; ie_we_i = iwe; wdata_i = wd;
    @(posedge clk);
    m_stat = nxt(m_stat, e, m_ie, swe, wd);
    if (iwe) m_ie = wd & CAPM;
    #2;
    evt_i = 0; stat_we_i = 0; ie_we_i = 0; wdata_i = 0;
  endtask

  task automatic cmp_all(input string req);
    check(stat_o === view(m_stat), req, stat_o, view(m_stat));
    check(ie_o === m_ie, {req, " R10"}, ie_o, m_ie);
    check(irq_o === (m_stat != 0), {req, " R8"}, {31'b0, irq_o}, {31'b0, m_stat != 0});
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    check(stat_o === 0 && ie_o === 0 && irq_o === 0, "R1", stat_o | ie_o, 0);
    rst_n = 1;

    // R3: events with everything disabled are ignored
    cyc(32'hFFFF_FFFF, 0, 0, 0);
    check(stat_o === 0, "R3", stat_o, 0);

    // R10 / R9: enable write masked
    cyc(0, 0, 1, 32'hFFFF_FFFF);
    check(ie_o === CAPM, "R10 R9", ie_o, CAPM);

    // R2: each capturable position alone
    for (int b = 0; b < 32; b++) begin
      if (CAPM[b]) begin
        cyc(32'h1 << b, 0, 0, 0);
        check(stat_o === view(32'h1 << b), "R2", stat_o, view(32'h1 << b));
        cyc(0, 1, 0, 32'hFFFF_FFFF);
      end
    end

    // R9: unused positions never latch
    cyc(~CAPM, 0, 0, 0);
    check(stat_o === 0, "R9", stat_o, 0);

    // R4 partial clear, R11 hold
    cyc(32'h0030_0013, 0, 0, 0);
    cyc(0, 0, 0, 0);
    check(stat_o === view(32'h0030_0013), "R11", stat_o, view(32'h0030_0013));
    cyc(0, 1, 0, 32'h0010_0001);
    check(stat_o === view(32'h0020_0012), "R4", stat_o, view(32'h0020_0012));

    // R7: writing bit 15 does not clear the summary
    cyc(0, 1, 0, 32'h0000_8000);
    check(stat_o[15] === 1'b1, "R7", stat_o, view(32'h0020_0012));
    cyc(0, 1, 0, 32'h0020_0000);
    check(stat_o === 32'h0000_0012, "R7", stat_o, 32'h12);

    // R5: all ones clears
    cyc(32'h3000_0021, 0, 0, 0);
    cyc(0, 1, 0, 32'hFFFF_FFFF);
    check(stat_o === 0 && irq_o === 0, "R5", stat_o, 0);

    // R6: event and clear collide
    cyc(32'h0000_0002, 0, 0, 0);
    cyc(32'h0000_0002, 1, 0, 32'hFFFF_FFFF);
    check(stat_o === 32'h2, "R6", stat_o, 32'h2);
    cyc(0, 1, 0, 32'hFFFF_FFFF);

    // R3 after partial enable
    cyc(0, 0, 1, 32'h0001_0001);
    cyc(32'h0002_0002, 0, 0, 0);
    check(stat_o === 0, "R3", stat_o, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] e, wd;
      logic swe, iwe;
      e   = $urandom & $urandom & $urandom;
      swe = ($urandom % 4) == 0;
      iwe = ($urandom % 16) == 0;
      wd  = (($urandom % 8) == 0) ? 32'hFFFF_FFFF : $urandom;
      cyc(e, swe, iwe, wd);
      cmp_all("R2 R4 R6 R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule